// File: doc/BRIEF.md
# Self-Reversing Up/Down Counter

A small synchronous counter whose direction of travel comes from its own most significant state bit. While the top bit is set, the counter climbs. While the top bit is clear, it descends. When it reaches either end of its range, it does not wrap. Instead it loads a fixed constant that hands it to the other half of the range. The result is a closed 16-state loop for the default 4-bit width. The loop runs upward through the upper half and then downward through the lower half.

The low bits, taken without the top bit, sweep up and then back down, which gives a triangle pattern. Each end value of that pattern lasts for two clocks. A direction flag reports which way the counter is moving. All state changes, including the synchronous active-low reset, happen on the rising clock edge. There is no asynchronous clear and no external load path.

Top module: `sru_counter`

## Requirements
- R1: When `rst_n` is sampled low at a rising clock edge, the state after that edge is 1000 (decimal 8) and `dir_up_o` is 1.
- R2: When the state has its top bit set and is not 1111, the next state is the current state plus one.
- R3: When the state is 1111, the next state is 0111 (decimal 7) rather than wrapping to 0000.
- R4: When the state has its top bit clear and is not 0000, the next state is the current state minus one.
- R5: When the state is 0000, the next state is 1000 rather than wrapping to 1111.
- R6: `dir_up_o` equals bit 3 of `count_o`, where 1 means counting up and 0 means counting down. It changes only on the step out of 1111 or out of 0000.
- R7: `tri_o` equals bits 2:0 of `count_o`. It therefore runs 0,1,…,7,7,6,…,0,0,1,…, with each end value present on two consecutive clocks.
- R8: From reset the decimal cycle is 8,9,10,11,12,13,14,15,7,6,5,4,3,2,1,0 with period 16. A reset in the middle of the cycle restarts it from 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_o | output | 4 | Counter state |
| dir_up_o | output | 1 | Direction flag, 1 = counting up |
| tri_o | output | 3 | Low state bits (triangle pattern) |

## Verification
The bench targets the two fold points. A design that wraps at 1111 or 0000 would show a period other than 16 and would lose the two-clock hold of 7 and 0 on the low bits. The bench also checks the direction flag at the folds, where an off-by-one decode would flip it one state early or one state late. Resets are fired at random points, including on the fold states. This exposes a reset value other than 8, and it also exposes a design that resumes from the old state instead of restarting the cycle.

// File: rtl/sru_pkg.sv
package sru_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } sru_dir_e;
endpackage

// File: rtl/sru_next.sv
module sru_next
  import sru_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o,
  output sru_dir_e     dir_o
);
  localparam int          MSB         = W - 1;
  localparam logic [W-1:0] TOP_END    = {W{1'b1}};
  localparam logic [W-1:0] BOT_END    = {W{1'b0}};
  localparam logic [W-1:0] UP_RELOAD  = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] DN_RELOAD  = {1'b1, {(W-1){1'b0}}};

  logic at_top, at_bot;

  always_comb begin
    dir_o  = cur_i[MSB] ? DIR_UP : DIR_DOWN;
    at_top = (cur_i == TOP_END);
    at_bot = (cur_i == BOT_END);
    if (at_top)              nxt_o = UP_RELOAD;
    else if (at_bot)         nxt_o = DN_RELOAD;
    else if (dir_o == DIR_UP) nxt_o = cur_i + 1'b1;
    else                     nxt_o = cur_i - 1'b1;
  end
endmodule

// File: rtl/sru_tri.sv
module sru_tri #(
  parameter int W       = 4,
  parameter bit HAS_TRI = 1'b1
) (
  input  logic [W-1:0] cnt_i,
  output logic [W-2:0] tri_o
);
  generate
    if (HAS_TRI) begin : g_tri
      assign tri_o = cnt_i[W-2:0];
    end else begin : g_no_tri
      assign tri_o = '0;
    end
  endgenerate
endmodule

// File: rtl/sru_counter.sv
module sru_counter
  import sru_pkg::*;
#(
  parameter int W       = 4,
  parameter bit HAS_TRI = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count_o,
  output logic         dir_up_o,
  output logic [W-2:0] tri_o
);
  localparam int           MSB       = W - 1;
  localparam logic [W-1:0] TOP_END   = {W{1'b1}};
  localparam logic [W-1:0] BOT_END   = {W{1'b0}};
  localparam logic [W-1:0] UP_RELOAD = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] RST_VAL   = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] cnt_q, cnt_d, step_nxt;
  sru_dir_e     dir;

  sru_next #(.W(W)) u_next (
    .cur_i (cnt_q),
    .nxt_o (step_nxt),
    .dir_o (dir)
  );

  always_comb begin
    cnt_d = rst_n ? step_nxt : RST_VAL;
  end

  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
  end

  sru_tri #(.W(W), .HAS_TRI(HAS_TRI)) u_tri (
    .cnt_i (cnt_q),
    .tri_o (tri_o)
  );

  assign count_o  = cnt_q;
  assign dir_up_o = (dir == DIR_UP);

  AST_RESET_LOAD: assert property (@(posedge clk)
    !rst_n |=> cnt_q == RST_VAL); // R1
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[MSB] && cnt_q != TOP_END) |=> cnt_q == W'($past(cnt_q) + 1'b1)); // R2
  AST_TOP_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP_END) |=> cnt_q == UP_RELOAD); // R3
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_q[MSB] && cnt_q != BOT_END) |=> cnt_q == W'($past(cnt_q) - 1'b1)); // R4
  AST_BOTTOM_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == BOT_END) |=> cnt_q == RST_VAL); // R5
  AST_DIR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != TOP_END && cnt_q != BOT_END) |=> $stable(dir_up_o)); // R6
  AST_TRI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_TRI && (cnt_q == TOP_END || cnt_q == BOT_END)) |=> $stable(tri_o)); // R7
endmodule

// File: tb/sru_counter_tb.sv
module sru_counter_tb_top;
  logic       clk;
  logic       rst_n;
  logic [3:0] count_o;
  logic       dir_up_o;
  logic [2:0] tri_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  sru_counter dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_o  (count_o),
    .dir_up_o (dir_up_o),
    .tri_o    (tri_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model_next(int s);
    if (s == 15) return 7;
    if (s == 0)  return 8;
    if (s >= 8)  return s + 1;
    return s - 1;
  endfunction

  function automatic int seq_at(int i);
    return (i < 8) ? 8 + i : 15 - i;
  endfunction

  function automatic string rule_for(int prev);
    if (prev == 15) return "R3";
    if (prev == 0)  return "R5";
    if (prev >= 8)  return "R2";
    return "R4";
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic chk_outputs(int exp, string req);
    chk(req, int'(count_o), exp);
    chk("R6", int'(dir_up_o), (exp >= 8) ? 1 : 0);
    chk("R7", int'(tri_o), exp % 8);
  endtask

  initial begin
    int exp;
    int prev_tri;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk_outputs(8, "R1");
    rst_n = 1'b1;
    // directed: three full periods starting at 8
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      chk("R8", int'(count_o), seq_at((i + 1) % 16));
      chk_outputs(seq_at((i + 1) % 16), rule_for(seq_at(i % 16)));
      if (seq_at(i % 16) == 15 || seq_at(i % 16) == 0)
        chk("R7", int'(tri_o), seq_at(i % 16) % 8);
    end
    // directed: reset right on the top fold state
    while (count_o != 4'd15) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_outputs(8, "R1");
    chk("R8", int'(count_o), 8);
    rst_n = 1'b1;
    exp = 8;
    // random mid-sequence resets
    for (int i = 0; i < 600; i++) begin
      prev_tri = exp % 8;
      rst_n = (($urandom % 23) == 0) ? 1'b0 : 1'b1;
      @(negedge clk);
      if (!rst_n) begin
        exp = 8;
        chk_outputs(exp, "R1");
      end else begin
        string r;
        r = rule_for(exp);
        exp = model_next(exp);
        chk_outputs(exp, r);
        if (r == "R3" || r == "R5") chk("R7", int'(tri_o), prev_tri);
      end
    end
    rst_n = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule